// File: doc/BRIEF.md
# Linear-Discharge Charge Digitiser Channel Controller

This block is the digital half of one channel of a linear-discharge charge digitiser. An external integrator collects the detector charge. A comparator reports when the integrator output has left its baseline. The controller answers by driving a discharge pin to a fixed logic level, which pulls a constant current out of the integrator. It releases the pin to high impedance once the comparator returns to its resting level. Because the current is constant, the number of clock cycles the comparator spends away from rest measures the collected charge. The controller counts those cycles and also latches a timestamp at the leading edge.

Each channel supports either input polarity, chosen by one input. In negative mode the comparator rests at 0, and the pin is driven to 1 during discharge. In positive mode the comparator rests at 1, and the pin is driven to 0. When a discharge ends, the channel stays deaf for a programmable number of cycles and then re-arms. The finished measurement leaves the block as a single-entry valid/ready stream. A record that finds the output slot still occupied is dropped and counted.

Back-pressure rules for the record stream are as follows. A record transfers on a rising clock edge where `ev_valid` and `ev_ready` are both high. While `ev_valid` is high and `ev_ready` is low, the record fields stay frozen. A new measurement overwrites nothing: it is discarded whenever the slot is still occupied and not being taken in that cycle.

Top module: `dq_channel`

## Requirements
- R1: After reset, `dis_oe` is 0 and the pin is released, `ev_valid` is 0, and `lost_cnt` is 0. Whenever no discharge is in progress, `dis_oe` stays 0.
- R2: With `pol_pos` = 0 (negative mode, comparator rest level 0), a 0-to-1 comparator transition starts a discharge. While discharging, `dis_oe` = 1 and `dis_out` = 1.
- R3: With `pol_pos` = 1 (positive mode, comparator rest level 1), a 1-to-0 comparator transition starts a discharge. While discharging, `dis_oe` = 1 and `dis_out` = 0.
- R4: The discharge ends, and `dis_oe` returns to 0, once the synchronised comparator is back at its rest level. The record becomes valid on the same edge.
- R5: `ev_width` equals the number of clock cycles the comparator input spent away from rest. A one-cycle excursion gives 1.
- R6: `ev_time` is the `ts_now` value sampled on the third rising edge after the comparator input leaves rest. That delay is two synchroniser stages plus the detection edge.
- R7: A comparator excursion that begins while a discharge or holdoff is in progress is ignored entirely. It produces no record, `dis_oe` stays 0, and the excursion is not picked up later.
- R8: The channel re-arms `holdoff` cycles after a discharge ends. An excursion detected after that point is accepted, and one detected before it is ignored.
- R9: The width counter saturates at all ones (255 by default) and never wraps. `ev_ovf` = 1 exactly when the reported width is saturated.
- R10: While `ev_valid` = 1 and `ev_ready` = 0, the record (`ev_time`, `ev_width`, `ev_ovf`) and `ev_valid` hold their values.
- R11: A record that completes while the slot holds an untaken record is dropped. `lost_cnt` then increments by one and saturates at all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_in | input | 1 | Raw comparator output, asynchronous |
| pol_pos | input | 1 | 1 = positive mode (rest level 1), 0 = negative mode (rest level 0) |
| holdoff | input | HOLD_W | Dead cycles after a discharge before re-arming |
| ts_now | input | TS_W | Free-running timestamp |
| dis_oe | output | 1 | Discharge pin output enable (0 = high impedance) |
| dis_out | output | 1 | Discharge pin data level |
| ev_valid | output | 1 | Record valid |
| ev_ready | input | 1 | Record accepted by consumer |
| ev_time | output | TS_W | Arrival timestamp |
| ev_width | output | WID_W | Excursion length in clock cycles (the charge) |
| ev_ovf | output | 1 | Width counter saturated |
| lost_cnt | output | LOST_W | Records dropped for lack of space, saturating |

## Verification
The assertions rely on two assumptions about the inputs. First, `pol_pos` only changes together with `cmp_in` moving to the new rest level, so the synchronised pair never shows a false excursion. Second, `holdoff` is held constant while a channel is busy. The stimulus follows both rules. Every polarity switch happens on one falling edge that sets both inputs together while the channel is idle, and `holdoff` is programmed once before reset is released. Comparator excursions are driven as clean whole-cycle levels on falling edges, so synchroniser metastability is never exercised and the measured width is exact.

// File: rtl/dq_pkg.sv
package dq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DIS  = 2'd1,
    ST_HOLD = 2'd2
  } dq_state_e;
endpackage

// File: rtl/dq_sync.sv
module dq_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dq_width_ctr.sv
module dq_width_ctr #(
  parameter int WID_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             run,
  output logic [WID_W-1:0] cnt,
  output logic             sat
);
  localparam logic [WID_W-1:0] ONE = WID_W'(1);

  assign sat = &cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (start)          cnt <= ONE;
    else if (run && !sat)    cnt <= cnt + ONE;
  end

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> (cnt >= $past(cnt))); // R9
endmodule

// File: rtl/dq_evt_slot.sv
module dq_evt_slot #(
  parameter int TS_W   = 16,
  parameter int WID_W  = 8,
  parameter int LOST_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [TS_W-1:0]   in_time,
  input  logic [WID_W-1:0]  in_width,
  input  logic              in_ovf,
  output logic              ev_valid,
  input  logic              ev_ready,
  output logic [TS_W-1:0]   ev_time,
  output logic [WID_W-1:0]  ev_width,
  output logic              ev_ovf,
  output logic [LOST_W-1:0] lost_cnt
);
  logic slot_free;
  assign slot_free = !ev_valid || ev_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_valid <= 1'b0;
      ev_time  <= '0;
      ev_width <= '0;
      ev_ovf   <= 1'b0;
      lost_cnt <= '0;
    end else begin
      if (load && slot_free) begin
        ev_valid <= 1'b1;
        ev_time  <= in_time;
        ev_width <= in_width;
        ev_ovf   <= in_ovf;
      end else if (ev_ready) begin
        ev_valid <= 1'b0;
      end
      if (load && !slot_free && !(&lost_cnt)) lost_cnt <= lost_cnt + 1'b1;
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && !ev_ready |=> ev_valid && $stable(ev_time) && $stable(ev_width) && $stable(ev_ovf)); // R10
  AST_LOST_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (lost_cnt != $past(lost_cnt)) |-> ($past(load) && $past(ev_valid) && !$past(ev_ready))); // R11
  AST_OVF_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && ev_ovf |-> (&ev_width)); // R9
endmodule

// File: rtl/dq_channel.sv
module dq_channel
  import dq_pkg::*;
#(
  parameter int TS_W   = 16,
  parameter int WID_W  = 8,
  parameter int HOLD_W = 8,
  parameter int LOST_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_in,
  input  logic              pol_pos,
  input  logic [HOLD_W-1:0] holdoff,
  input  logic [TS_W-1:0]   ts_now,
  output logic              dis_oe,
  output logic              dis_out,
  output logic              ev_valid,
  input  logic              ev_ready,
  output logic [TS_W-1:0]   ev_time,
  output logic [WID_W-1:0]  ev_width,
  output logic              ev_ovf,
  output logic [LOST_W-1:0] lost_cnt
);
  localparam int SYNC_STAGES = 2;
  localparam logic [HOLD_W-1:0] HOLD_ONE = HOLD_W'(1);

  logic [1:0]       sync_q;
  logic             pol_s, act, act_q, act_rise;
  dq_state_e        state;
  logic [HOLD_W-1:0] hcnt;
  logic [TS_W-1:0]  ts_cap;
  logic             drv_lvl;
  logic             start, done, run;
  logic [WID_W-1:0] cnt;
  logic             sat;

  dq_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({pol_pos, cmp_in}), .q(sync_q)
  );

  assign pol_s    = sync_q[1];
  assign act      = sync_q[0] ^ pol_s;
  assign act_rise = act && !act_q;
  assign start    = (state == ST_IDLE) && act_rise;
  assign run      = (state == ST_DIS) && act;
  assign done     = (state == ST_DIS) && !act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      state   <= ST_IDLE;
      hcnt    <= '0;
      ts_cap  <= '0;
      drv_lvl <= 1'b0;
    end else begin
      act_q <= act;
      unique case (state)
        ST_IDLE: if (start) begin
          state   <= ST_DIS;
          ts_cap  <= ts_now;
          drv_lvl <= !pol_s;
        end
        ST_DIS: if (done) begin
          if (holdoff == '0) state <= ST_IDLE;
          else begin
            state <= ST_HOLD;
            hcnt  <= holdoff;
          end
        end
        ST_HOLD: begin
          if (hcnt <= HOLD_ONE) state <= ST_IDLE;
          hcnt <= hcnt - HOLD_ONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign dis_oe  = (state == ST_DIS);
  assign dis_out = dis_oe && drv_lvl;

  dq_width_ctr #(.WID_W(WID_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .start(start), .run(run), .cnt(cnt), .sat(sat)
  );

  dq_evt_slot #(.TS_W(TS_W), .WID_W(WID_W), .LOST_W(LOST_W)) u_slot (
    .clk(clk), .rst_n(rst_n), .load(done),
    .in_time(ts_cap), .in_width(cnt), .in_ovf(sat),
    .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_time(ev_time), .ev_width(ev_width), .ev_ovf(ev_ovf),
    .lost_cnt(lost_cnt)
  );

  AST_OE_AFTER_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    dis_oe |-> $past(act)); // R4
  AST_REC_AFTER_DIS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ev_valid) |-> $past(dis_oe)); // R4
  AST_HOLD_NO_OE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dis_oe) |=> !dis_oe); // R7
endmodule

// File: tb/dq_channel_bench.sv
module dq_channel_bench;
  localparam int TS_W = 16, WID_W = 8, HOLD_W = 8, LOST_W = 8;
  localparam int HOLD = 6;
  localparam int WMAX = (1 << WID_W) - 1;

  logic clk = 0, rst_n = 0, cmp_in = 0, pol_pos = 0, ev_ready = 1;
  logic [HOLD_W-1:0] holdoff = HOLD_W'(HOLD);
  logic [TS_W-1:0] ts_now = '0;
  logic dis_oe, dis_out, ev_valid, ev_ovf;
  logic [TS_W-1:0] ev_time;
  logic [WID_W-1:0] ev_width;
  logic [LOST_W-1:0] lost_cnt;

  int nchk = 0, nfail = 0;
  bit finished = 0;

  typedef struct { int t; int w; bit o; } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;
  always @(posedge clk) ts_now <= ts_now + 1'b1;

  dq_channel #(.TS_W(TS_W), .WID_W(WID_W), .HOLD_W(HOLD_W), .LOST_W(LOST_W)) u_dq_channel (
    .clk(clk), .rst_n(rst_n), .cmp_in(cmp_in), .pol_pos(pol_pos), .holdoff(holdoff),
    .ts_now(ts_now), .dis_oe(dis_oe), .dis_out(dis_out), .ev_valid(ev_valid),
    .ev_ready(ev_ready), .ev_time(ev_time), .ev_width(ev_width), .ev_ovf(ev_ovf),
    .lost_cnt(lost_cnt)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // driver: one excursion of w cycles after pre idle cycles
  task automatic pulse(input int w, input int pre, input bit expect_rec, input bit probe);
    exp_t e;
    int t0;
    repeat (pre) @(negedge clk);
    t0 = int'(ts_now);
    cmp_in = !pol_pos;
    if (expect_rec) begin
      e.t = (t0 + 2) & ((1 << TS_W) - 1);
      e.w = (w > WMAX) ? WMAX : w;
      e.o = (w >= WMAX);
      q.push_back(e);
    end
    for (int i = 0; i < w; i++) begin
      @(negedge clk);
      if (probe && i == 3) begin
        if (!expect_rec)
          chk(dis_oe == 1'b0, "R7", "oe during ignored excursion", int'(dis_oe), 0);
        else begin
          chk(dis_oe == 1'b1, pol_pos ? "R3" : "R2", "oe during discharge", int'(dis_oe), 1);
          chk(dis_out == !pol_pos, pol_pos ? "R3" : "R2", "discharge level", int'(dis_out), int'(!pol_pos));
        end
      end
    end
    cmp_in = pol_pos;
  endtask

  task automatic end_check(input int w);
    repeat (2) @(negedge clk);
    chk(dis_oe == 1'b1, "R4", "oe still set before release", int'(dis_oe), 1);
    @(negedge clk);
    chk(dis_oe == 1'b0, "R4", "oe released after rest", int'(dis_oe), 0);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && ev_valid && ev_ready) begin
      if (q.size() == 0) chk(1'b0, "R7", "unexpected record width", int'(ev_width), 0);
      else begin
        exp_t e;
        e = q.pop_front();
        chk(int'(ev_time) == e.t, "R6", "timestamp", int'(ev_time), e.t);
        chk(int'(ev_width) == e.w, "R5", "width", int'(ev_width), e.w);
        chk(ev_ovf == e.o, "R9", "overflow flag", int'(ev_ovf), int'(e.o));
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(dis_oe == 0, "R1", "oe in reset", int'(dis_oe), 0);
    chk(ev_valid == 0, "R1", "valid in reset", int'(ev_valid), 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(dis_oe == 0 && lost_cnt == 0, "R1", "idle oe/lost", int'(dis_oe) + int'(lost_cnt), 0);

    // negative mode
    pulse(20, 2, 1, 1); end_check(20);
    pulse(1, 12, 1, 0);
    pulse(7, 12, 1, 1);
    pulse(33, 12, 1, 1);

    // switch to positive mode while idle
    repeat (12) @(negedge clk);
    pol_pos = 1; cmp_in = 1;
    repeat (8) @(negedge clk);
    chk(dis_oe == 0, "R1", "no event on polarity switch", int'(dis_oe), 0);
    pulse(12, 2, 1, 1); end_check(12);
    pulse(3, 12, 1, 0);

    // holdoff: ignored during hold (R7), accepted after re-arm (R8)
    pulse(10, 12, 1, 0);
    pulse(5, 1, 0, 1);
    pulse(10, 15, 1, 0);
    pulse(5, HOLD - 1, 0, 1);
    pulse(10, 15, 1, 0);
    pulse(6, HOLD + 1, 1, 1);   // R8 re-armed

    // saturation R9
    pulse(300, 12, 1, 0);

    // back-pressure R10/R11
    repeat (12) @(negedge clk);
    ev_ready = 0;
    pulse(8, 2, 1, 0);
    pulse(9, 12, 0, 0);
    repeat (12) @(negedge clk);
    chk(ev_valid == 1, "R10", "record held", int'(ev_valid), 1);
    chk(int'(ev_width) == 8, "R10", "held width", int'(ev_width), 8);
    chk(int'(lost_cnt) == 1, "R11", "lost count", int'(lost_cnt), 1);
    ev_ready = 1;
    repeat (20) @(negedge clk);
    chk(q.size() == 0, "R5", "records outstanding", q.size(), 0);
    chk(ev_valid == 0, "R10", "slot drained", int'(ev_valid), 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule